// File: doc/BRIEF.md
# Request/Response Memory Target

This block is the target end of a synchronous, one-way, point-to-point socket between an initiator and a target. The initiator places a command, an address and, for direct writes, a data word on the request pins. The target raises an accept pin in the same cycle once it can take that request. Reads are answered some cycles later with a response code and a data word. Writes are posted and are never answered. The target holds a small word-addressed memory, and the response latency is a parameter.

A build-time option separates write data from the write request. In that mode an accepted write only reserves a one-entry buffer. Its data then arrives over a separate valid/ready exchange, so an initiator can issue a write before its data is ready. The phases always run in the same order: request, then write data, then response.

Back-pressure rules:
- The request side is held-until-accepted. The initiator keeps `req_cmd`, `req_addr` and `req_wdata` stable until `req_accept` is high in that cycle.
- The write-data side is valid/ready. `wd_valid` and `wd_data` stay stable until `wd_accept` is high, and a word moves on a clock edge where both are high.
- The response side has no back-pressure. A response is a one-cycle pulse, and the initiator must take it.

Top module: `rr_mem_target`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rsp_code` is 0 and `wd_accept` is 0.
- R2: Command value 1 means write and command value 2 means read. Every other value (0 and 3 to 7) is idle. An idle command is never accepted and produces no response.
- R3: A read is accepted, with `req_accept` high in the same cycle, when no read is in flight and no write is waiting for its data.
- R4: A read at an in-range address (below DEPTH, 40 by default) is answered in the cycle that comes RD_LAT cycles after its accept cycle (3 by default). The answer is `rsp_code` = 1 with the word stored at that address, and it lasts exactly one cycle. In every other cycle `rsp_code` is 0.
- R5: A read at an address of DEPTH or above is answered at the same time with `rsp_code` = 3 and `rsp_rdata` = 0.
- R6: A write never produces a response. `rsp_code` stays 0 during and after it.
- R7: At most one read is in flight. A read presented while another is in flight gets no accept until the cycle after that earlier read's response.
- R8: In separate-data mode (SPLIT_WDATA = 1), an accepted write raises `wd_accept` from the next cycle until the data transfer. The word stored is `wd_data` from the transfer cycle, and `req_wdata` is ignored. `wd_accept` is low whenever no write is buffered.
- R9: In separate-data mode, while a write waits for its data, neither reads nor writes are accepted. This includes the transfer cycle itself. A read accepted afterwards returns the newly written word.
- R10: In direct mode (SPLIT_WDATA = 0), a write stores `req_wdata` in its accept cycle, `wd_accept` stays 0, and a read of the same address in the next cycle is accepted and returns that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_cmd | input | 3 | Command: 0 idle, 1 write, 2 read, others idle |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data, direct mode only |
| req_accept | output | 1 | Request taken this cycle |
| wd_valid | input | 1 | Write data offered (separate-data mode) |
| wd_data | input | DATA_W | Write data word (separate-data mode) |
| wd_accept | output | 1 | Target ready for the buffered write's data |
| rsp_code | output | 3 | Response: 0 none, 1 data valid, 3 error |
| rsp_rdata | output | DATA_W | Read data, 0 on error |

## Verification
The checker assumes that reset is applied from time zero and that `req_cmd`, `wd_valid` and `wd_accept` are always known. It also assumes the initiator offers write data only for a write that has already been accepted. The bench drives every input half a cycle away from the rising edge. It holds each request until it is accepted and raises `wd_valid` only in cycles after that write's accept. It waits for each read's answer before it issues another read, except in the one test that presents a read while another is in flight, to check R7.

// File: rtl/rr_pkg.sv
package rr_pkg;

  localparam logic [2:0] CMD_IDLE = 3'd0;
  localparam logic [2:0] CMD_WR   = 3'd1;
  localparam logic [2:0] CMD_RD   = 3'd2;

  localparam logic [2:0] RSP_NONE = 3'd0;
  localparam logic [2:0] RSP_DVA  = 3'd1;
  localparam logic [2:0] RSP_ERR  = 3'd3;

  typedef enum logic [1:0] {OP_NONE, OP_WR, OP_RD} op_e;

  function automatic op_e decode_cmd(input logic [2:0] c);
    case (c)
      CMD_WR:  return OP_WR;
      CMD_RD:  return OP_RD;
      default: return OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/rr_store.sv
module rr_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 40
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic              rhit,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic whit;

  assign whit = {1'b0, waddr} < LIMIT;
  assign rhit = {1'b0, raddr} < LIMIT;

  always_ff @(posedge clk) begin
    if (we && whit) mem[waddr[IDX_W-1:0]] <= wdata;
  end

  assign rdata = rhit ? mem[raddr[IDX_W-1:0]] : '0;
endmodule

// File: rtl/rr_rd_pipe.sv
module rr_rd_pipe #(
  parameter int DATA_W = 16,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              hit,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic [2:0]        rsp_code,
  output logic [DATA_W-1:0] rsp_data
);
  import rr_pkg::*;

  logic [LAT-1:0]    vld;
  logic [LAT-1:0]    err;
  logic [DATA_W-1:0] dat [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld[0] <= 1'b0;
      err[0] <= 1'b0;
      dat[0] <= '0;
    end else begin
      vld[0] <= launch;
      err[0] <= launch && !hit;
      dat[0] <= (launch && hit) ? data : '0;
    end
  end

  for (genvar g = 1; g < LAT; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[g] <= 1'b0;
        err[g] <= 1'b0;
        dat[g] <= '0;
      end else begin
        vld[g] <= vld[g-1];
        err[g] <= err[g-1];
        dat[g] <= dat[g-1];
      end
    end
  end

  assign busy     = |vld;
  assign rsp_code = !vld[LAT-1] ? RSP_NONE : (err[LAT-1] ? RSP_ERR : RSP_DVA);
  assign rsp_data = dat[LAT-1];
endmodule

// File: rtl/rr_wr_stage.sv
module rr_wr_stage #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter bit SPLIT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              wd_valid,
  input  logic [DATA_W-1:0] wd_data,
  output logic              wd_accept,
  output logic              pend,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata
);
  if (SPLIT) begin : g_split
    logic              pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic              xfer;
    logic              unused_req_wdata;

    assign unused_req_wdata = ^req_wdata;
    assign xfer = wd_valid && pend_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        addr_q <= '0;
      end else if (take) begin
        pend_q <= 1'b1;
        addr_q <= req_addr;
      end else if (xfer) begin
        pend_q <= 1'b0;
      end
    end

    assign wd_accept = pend_q;
    assign pend      = pend_q;
    assign mem_we    = xfer;
    assign mem_waddr = addr_q;
    assign mem_wdata = wd_data;
  end else begin : g_direct
    logic unused_wd;

    assign unused_wd = wd_valid ^ (^wd_data) ^ clk ^ rst_n;
    assign wd_accept = 1'b0;
    assign pend      = 1'b0;
    assign mem_we    = take;
    assign mem_waddr = req_addr;
    assign mem_wdata = req_wdata;
  end
endmodule

// File: rtl/rr_mem_target.sv
module rr_mem_target #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int DEPTH       = 40,
  parameter int RD_LAT      = 3,
  parameter bit SPLIT_WDATA = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_accept,
  input  logic              wd_valid,
  input  logic [DATA_W-1:0] wd_data,
  output logic              wd_accept,
  output logic [2:0]        rsp_code,
  output logic [DATA_W-1:0] rsp_rdata
);
  import rr_pkg::*;

  op_e               op;
  logic              rd_busy, wr_pend, rd_take, wr_take;
  logic              mem_we, rhit;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata, rdata;

  assign op         = decode_cmd(req_cmd);
  assign rd_take    = (op == OP_RD) && !rd_busy && !wr_pend;
  assign wr_take    = (op == OP_WR) && !wr_pend;
  assign req_accept = rd_take || wr_take;

  rr_wr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPLIT(SPLIT_WDATA)) u_wr (
    .clk(clk), .rst_n(rst_n), .take(wr_take),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .wd_valid(wd_valid), .wd_data(wd_data), .wd_accept(wd_accept),
    .pend(wr_pend), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  rr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(req_addr), .rhit(rhit), .rdata(rdata)
  );

  rr_rd_pipe #(.DATA_W(DATA_W), .LAT(RD_LAT)) u_rd (
    .clk(clk), .rst_n(rst_n), .launch(rd_take), .hit(rhit), .data(rdata),
    .busy(rd_busy), .rsp_code(rsp_code), .rsp_data(rsp_rdata)
  );
endmodule

// File: rtl/rr_mem_target_chk.sv
module rr_mem_target_chk #(
  parameter int DATA_W      = 16,
  parameter int RD_LAT      = 3,
  parameter bit SPLIT_WDATA = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        req_cmd,
  input logic              req_accept,
  input logic              wd_valid,
  input logic              wd_accept,
  input logic [2:0]        rsp_code,
  input logic [DATA_W-1:0] rsp_rdata
);
  import rr_pkg::*;

  localparam int AGE_W = $clog2(RD_LAT + 2);

  logic             rd_out;
  logic [AGE_W-1:0] age;
  logic             wpend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_out <= 1'b0;
      age    <= '0;
      wpend  <= 1'b0;
    end else begin
      if (req_accept && req_cmd == CMD_RD) begin
        rd_out <= 1'b1;
        age    <= AGE_W'(1);
      end else if (rsp_code != RSP_NONE) begin
        rd_out <= 1'b0;
      end else if (rd_out) begin
        age <= age + AGE_W'(1);
      end
      if (SPLIT_WDATA && req_accept && req_cmd == CMD_WR) wpend <= 1'b1;
      else if (wd_valid && wd_accept) wpend <= 1'b0;
    end
  end

  AST_ACCEPT_ONLY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> (req_cmd == CMD_WR || req_cmd == CMD_RD)); // R2
  AST_RSP_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_code == RSP_NONE || rsp_code == RSP_DVA || rsp_code == RSP_ERR)); // R4
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_code != RSP_NONE) |-> (rd_out && age == AGE_W'(RD_LAT))); // R4
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_code == RSP_ERR) |-> (rsp_rdata == '0)); // R5
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_accept && req_cmd == CMD_RD) |-> !rd_out); // R7
  AST_WD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    wd_accept |-> wpend); // R8
  AST_HOLD_WHILE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    wpend |-> !req_accept); // R9
endmodule

bind rr_mem_target rr_mem_target_chk #(
  .DATA_W(DATA_W), .RD_LAT(RD_LAT), .SPLIT_WDATA(SPLIT_WDATA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_accept(req_accept),
  .wd_valid(wd_valid), .wd_accept(wd_accept), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata)
);

// File: tb/sim_rr_mem_target.sv
`timescale 1ns/1ps
module sim_rr_mem_target;
  localparam int AW = 6, DW = 16, DEPTH = 40, LAT = 3;
  localparam int NV = 12;
  // entry: {op[1:0] (1 write, 2 read), addr[5:0], data[15:0]}
  localparam logic [23:0] VEC [NV] = '{
    {2'd1, 6'd1,  16'h1111}, {2'd1, 6'd2,  16'h2222}, {2'd2, 6'd1,  16'h0000},
    {2'd1, 6'd39, 16'hA5A5}, {2'd2, 6'd39, 16'h0000}, {2'd2, 6'd40, 16'h0000},
    {2'd1, 6'd0,  16'h0F0F}, {2'd2, 6'd0,  16'h0000}, {2'd2, 6'd63, 16'h0000},
    {2'd1, 6'd1,  16'h3C3C}, {2'd2, 6'd1,  16'h0000}, {2'd2, 6'd2,  16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cmd = '0;  logic [AW-1:0] addr = '0;  logic [DW-1:0] wdata = '0;
  logic wdv = 1'b0;      logic [DW-1:0] wdd = '0;
  logic acc, wda;        logic [2:0] code;         logic [DW-1:0] rdata;
  logic [2:0] cmd1 = '0; logic [AW-1:0] addr1 = '0; logic [DW-1:0] wdata1 = '0;
  logic acc1, wda1;      logic [2:0] code1;        logic [DW-1:0] rdata1;
  logic [DW-1:0] model [64];
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  rr_mem_target #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .RD_LAT(LAT), .SPLIT_WDATA(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_cmd(cmd), .req_addr(addr), .req_wdata(wdata),
    .req_accept(acc), .wd_valid(wdv), .wd_data(wdd), .wd_accept(wda),
    .rsp_code(code), .rsp_rdata(rdata));

  rr_mem_target #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .RD_LAT(LAT), .SPLIT_WDATA(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_cmd(cmd1), .req_addr(addr1), .req_wdata(wdata1),
    .req_accept(acc1), .wd_valid(1'b0), .wd_data('0), .wd_accept(wda1),
    .rsp_code(code1), .rsp_rdata(rdata1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic rd_tail(input logic [2:0] ec, input logic [DW-1:0] ed, input string tag);
    @(negedge clk); cmd = 3'd0;
    for (int k = 1; k < LAT; k++) begin
      #1; chk({tag, " quiet before latency"}, code, 0);
      @(negedge clk);
    end
    #1; chk({tag, " code"}, code, ec); chk({tag, " data"}, rdata, ed);
    @(negedge clk); #1; chk("R4 response lasts one cycle", code, 0);
  endtask

  task automatic rd0(input logic [AW-1:0] a);
    logic [2:0] ec; logic [DW-1:0] ed;
    ec = (a < DEPTH) ? 3'd1 : 3'd3;
    ed = (a < DEPTH) ? model[a] : '0;
    @(negedge clk); cmd = 3'd2; addr = a;
    #1; while (!acc) begin @(negedge clk); #1; end
    rd_tail(ec, ed, (a < DEPTH) ? "R4 read" : "R5 out-of-range read");
  endtask

  task automatic wr0(input logic [AW-1:0] a, input logic [DW-1:0] d, input int gap);
    @(negedge clk); cmd = 3'd1; addr = a; wdata = ~d;
    #1; while (!acc) begin @(negedge clk); #1; end
    @(negedge clk); cmd = 3'd0;
    for (int k = 0; k < gap; k++) begin
      #1; chk("R8 data-accept waiting", wda, 1); chk("R6 no write response", code, 0);
      @(negedge clk);
    end
    wdv = 1'b1; wdd = d;
    #1; chk("R8 data accept up", wda, 1);
    @(negedge clk); wdv = 1'b0;
    #1; chk("R8 buffer released", wda, 0); chk("R6 no write response", code, 0);
    if (a < DEPTH) model[a] = d;
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 code in reset", code, 0); chk("R1 data-accept in reset", wda, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 code after reset", code, 0); chk("R1 data-accept after reset", wda, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][23:22] == 2'd1) wr0(VEC[i][21:16], VEC[i][15:0], i % 3);
      else rd0(VEC[i][21:16]);
    end

    // R2: idle command values never accepted, never answered
    foreach (VEC[j]) begin
      if (j < 8 && j != 1 && j != 2) begin
        @(negedge clk); cmd = 3'(j); addr = 6'd3;
        #1; chk("R2 idle value not accepted", acc, 0);
      end
    end
    @(negedge clk); cmd = 3'd0;
    for (int k = 0; k <= LAT; k++) begin
      #1; chk("R2 no response to idle", code, 0); chk("R2 no buffered write", wda, 0);
      @(negedge clk);
    end

    // R3 / R7: second read waits for the first read's response
    @(negedge clk); cmd = 3'd2; addr = 6'd1;
    #1; chk("R3 read accepted at once", acc, 1);
    @(negedge clk); addr = 6'd2;
    for (int k = 1; k <= LAT; k++) begin
      #1; chk("R7 second read blocked", acc, 0);
      if (k == LAT) begin
        chk("R7 first read code", code, 1); chk("R7 first read data", rdata, model[1]);
      end
      @(negedge clk);
    end
    #1; chk("R7 second read accepted after response", acc, 1);
    rd_tail(3'd1, model[2], "R7 second read");

    // R8 / R9: buffered write blocks traffic, req_wdata ignored
    @(negedge clk); cmd = 3'd1; addr = 6'd7; wdata = 16'hDEAD;
    #1; chk("R8 write request accepted", acc, 1);
    @(negedge clk); addr = 6'd8;
    #1; chk("R9 write blocked while buffered", acc, 0); chk("R8 data-accept up", wda, 1);
    @(negedge clk); cmd = 3'd2; addr = 6'd7; wdv = 1'b1; wdd = 16'hBEEF;
    #1; chk("R9 read blocked in transfer cycle", acc, 0);
    @(negedge clk); wdv = 1'b0; model[7] = 16'hBEEF;
    #1; chk("R9 read accepted after transfer", acc, 1); chk("R8 data-accept down", wda, 0);
    rd_tail(3'd1, 16'hBEEF, "R9 read sees written word");

    // R10: direct mode on u1
    @(negedge clk); cmd1 = 3'd1; addr1 = 6'd9; wdata1 = 16'h1234;
    #1; chk("R10 direct write accepted", acc1, 1); chk("R10 no data-accept", wda1, 0);
    @(negedge clk); cmd1 = 3'd2;
    #1; chk("R10 read accepted next cycle", acc1, 1);
    @(negedge clk); cmd1 = 3'd0;
    repeat (LAT - 1) @(negedge clk);
    #1; chk("R10 read code", code1, 1); chk("R10 read data", rdata1, 16'h1234);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule